// File: doc/BRIEF.md
# Second-Order Five-Bit Noise Shaper

This block reduces a stream of 18-bit two's complement audio samples, arriving at the 96x oversampled rate, to 5-bit two's complement codes. A second-order error-feedback loop pushes the quantisation error out of the audio band. The error shaping follows (1 - z^-1)^2, so the long-run average of the coarse codes still follows the fine input. Left and right samples share one arithmetic path. Each sample carries a channel index, and every channel keeps its own two-deep error history.

Each code stands for a level at the centre of its quantiser step, which is code times 8192 plus 4096. Because of this, a silent input does not hold one code. Instead it settles into a two-level, 1-bit-like stream between 0 and -1. Larger signals use all 32 codes. At the ends of the range the codes saturate, and the stored error is clamped so that the loop recovers as soon as the overload ends.

Top module: `nshp_top`

## Requirements
- R1: A synchronous active-low reset clears `out_valid`, `out_chan`, `out_code` and the error history of every channel. The first sample after reset therefore sees zero history.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and low otherwise. `out_chan` repeats the channel of that sample. `out_code` and `out_chan` hold while no sample arrives.
- R3: For sample x on channel c with history e1 (newest) and e2, the block forms v = x + 2*e1 - e2. The code is floor(v / 8192), limited to [-16, +15]. The represented level is code*8192 + 4096. The new error v - level, clamped to [-8192, +8191], becomes e1, and the old e1 becomes e2.
- R4: A positive full-scale input (+131071) held on a channel gives code +15 on every sample. A negative full-scale input (-131072) held gives code -16 on every sample.
- R5: After a run of negative full-scale samples, the error clamp lets the loop recover. From the fifth zero sample on, every code is 0 or -1.
- R6: Channel index 0 is left and 1 is right. A sample on one channel leaves the error history of the other channel unchanged. Cycles without a sample change no history.
- R7: With zero history, zero input on a channel gives the repeating code sequence 0, -1, -1, 0. This is a two-level stream with a mean of -0.5 code.
- R8: For N consecutive non-saturating samples of constant value x on one channel, the sum of represented levels differs from N*x by at most 32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A sample is present this cycle |
| in_chan | input | 1 | Channel of the sample: 0 left, 1 right |
| in_sample | input | 18 | Input sample, two's complement |
| out_valid | output | 1 | A code is present this cycle |
| out_chan | output | 1 | Channel of the code |
| out_code | output | 5 | Shaped output code, two's complement, -16..+15 |

## Verification
The hardest state to reach from the ports is the error clamp in action. Ordinary audio-like input never drives the quantiser past its range, so the clamp is not used. The stimulus holds each full-scale polarity for several consecutive samples on one channel until the stored error pins at its limit. It then switches to silence and follows the recovery code by code. Isolation between channels is exercised in a second way: one channel's idle pattern is broken off halfway, the other channel is overloaded, idle cycles are inserted, and the first channel must resume at the exact phase where it stopped.

// File: rtl/nshp_pkg.sv
// Shared constants and helpers for the noise shaper.
// Assumes: widths are given in bits; channel count is at least 1.
package nshp_pkg;

    localparam int NS_IN_W     = 18;
    localparam int NS_OUT_W    = 5;
    localparam int NS_CHANNELS = 2;

    // Width of a channel index; never below one bit.
    function automatic int chan_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/nshp_feedback_sum.sv
// Adds the shaped error feedback to an input sample: acc = x + 2*e1 - e2.
// Assumes: ACC_W leaves headroom for the sample plus three error magnitudes.
module nshp_feedback_sum #(
    parameter int IN_W  = 18,
    parameter int ERR_W = 14,
    parameter int ACC_W = 20
) (
    input  logic signed [IN_W-1:0]  sample,
    input  logic signed [ERR_W-1:0] err_d1,
    input  logic signed [ERR_W-1:0] err_d2,
    output logic signed [ACC_W-1:0] acc
);

    logic signed [ACC_W-1:0] x_ext;
    logic signed [ACC_W-1:0] e1_ext;
    logic signed [ACC_W-1:0] e2_ext;

    // Sign-extend all operands to the accumulator width.
    always_comb begin
        x_ext  = {{(ACC_W-IN_W){sample[IN_W-1]}}, sample};
        e1_ext = {{(ACC_W-ERR_W){err_d1[ERR_W-1]}}, err_d1};
        e2_ext = {{(ACC_W-ERR_W){err_d2[ERR_W-1]}}, err_d2};
    end

    // Second-order error feedback sum.
    always_comb begin
        acc = x_ext + (e1_ext <<< 1) - e2_ext;
    end

endmodule

// File: rtl/nshp_quantizer.sv
// Mid-rise quantiser: keeps the top bits of the sum, saturates them to the
// output code range, and returns the clamped difference to the level the code
// represents (code * 2^SHIFT + 2^(SHIFT-1)).
// Assumes: ERR_W == SHIFT + 1 and ACC_W > SHIFT + OUT_W.
module nshp_quantizer #(
    parameter int ACC_W = 20,
    parameter int SHIFT = 13,
    parameter int OUT_W = 5,
    parameter int ERR_W = 14
) (
    input  logic signed [ACC_W-1:0] acc,
    output logic signed [OUT_W-1:0] code,
    output logic signed [ERR_W-1:0] err_new
);

    localparam int QW = ACC_W - SHIFT;
    localparam logic signed [QW-1:0]    Q_MAX = QW'((1 << (OUT_W-1)) - 1);
    localparam logic signed [QW-1:0]    Q_MIN = QW'(-(1 << (OUT_W-1)));
    localparam logic signed [ACC_W-1:0] E_MAX = ACC_W'((1 << SHIFT) - 1);
    localparam logic signed [ACC_W-1:0] E_MIN = ACC_W'(-(1 << SHIFT));

    logic signed [QW-1:0]    q_raw;
    logic signed [QW-1:0]    q_sat;
    logic signed [ACC_W-1:0] level;
    logic signed [ACC_W-1:0] diff;
    logic signed [ACC_W-1:0] diff_clamped;

    // Floor division by 2^SHIFT, then limit to the code range.
    always_comb begin
        q_raw = acc[ACC_W-1:SHIFT];
        if (q_raw > Q_MAX) begin
            q_sat = Q_MAX;
        end else if (q_raw < Q_MIN) begin
            q_sat = Q_MIN;
        end else begin
            q_sat = q_raw;
        end
    end

    assign code  = q_sat[OUT_W-1:0];
    assign level = {q_sat, 1'b1, {(SHIFT-1){1'b0}}};
    assign diff  = acc - level;

    // Bound the error so an overload cannot wind up the loop.
    always_comb begin
        if (diff > E_MAX) begin
            diff_clamped = E_MAX;
        end else if (diff < E_MIN) begin
            diff_clamped = E_MIN;
        end else begin
            diff_clamped = diff;
        end
    end

    assign err_new = diff_clamped[ERR_W-1:0];

endmodule

// File: rtl/nshp_err_bank.sv
// Per-channel two-deep error history. Reads the selected channel
// combinationally and, on a write, shifts the new error into that channel only.
// Assumes: read and write address the same channel in a cycle.
module nshp_err_bank #(
    parameter int CHANNELS = 2,
    parameter int ERR_W    = 14,
    parameter int CH_W     = 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [CH_W-1:0]              chan,
    input  logic signed [ERR_W-1:0]      wr_err,
    output logic signed [ERR_W-1:0]      rd_d1,
    output logic signed [ERR_W-1:0]      rd_d2,
    output logic [CHANNELS*2*ERR_W-1:0]  state_flat
);

    logic signed [ERR_W-1:0] d1_q [CHANNELS];
    logic signed [ERR_W-1:0] d2_q [CHANNELS];

    // Clear on reset; shift history of the written channel.
    always_ff @(posedge clk) begin
        for (int c = 0; c < CHANNELS; c++) begin
            if (!rst_n) begin
                d1_q[c] <= '0;
                d2_q[c] <= '0;
            end else if (wr_en && (chan == CH_W'(c))) begin
                d2_q[c] <= d1_q[c];
                d1_q[c] <= wr_err;
            end
        end
    end

    // Read port for the channel being processed.
    always_comb begin
        rd_d1 = d1_q[chan];
        rd_d2 = d2_q[chan];
    end

    // Flattened view of all history, one slice per channel.
    generate
        for (genvar g = 0; g < CHANNELS; g++) begin : g_flat
            assign state_flat[g*2*ERR_W +: 2*ERR_W] = {d2_q[g], d1_q[g]};
        end
    endgenerate

endmodule

// File: rtl/nshp_top.sv
// Second-order five-bit noise shaper with a time-shared datapath.
// One sample per cycle at most; output registered one cycle after input.
// Assumes: in_chan < CHANNELS whenever in_valid is high.
module nshp_top import nshp_pkg::*; #(
    parameter int IN_W     = NS_IN_W,
    parameter int OUT_W    = NS_OUT_W,
    parameter int CHANNELS = NS_CHANNELS
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               in_valid,
    input  logic [chan_bits(CHANNELS)-1:0]     in_chan,
    input  logic signed [IN_W-1:0]             in_sample,
    output logic                               out_valid,
    output logic [chan_bits(CHANNELS)-1:0]     out_chan,
    output logic signed [OUT_W-1:0]            out_code
);

    localparam int CH_W  = chan_bits(CHANNELS);
    localparam int SHIFT = IN_W - OUT_W;
    localparam int ERR_W = SHIFT + 1;
    localparam int ACC_W = IN_W + 2;

    logic signed [ERR_W-1:0]     hist_d1;
    logic signed [ERR_W-1:0]     hist_d2;
    logic signed [ERR_W-1:0]     err_next;
    logic signed [ACC_W-1:0]     loop_acc;
    logic signed [OUT_W-1:0]     code_next;
    logic [CHANNELS*2*ERR_W-1:0] err_state_flat;

    nshp_err_bank #(
        .CHANNELS (CHANNELS),
        .ERR_W    (ERR_W),
        .CH_W     (CH_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (in_valid),
        .chan       (in_chan),
        .wr_err     (err_next),
        .rd_d1      (hist_d1),
        .rd_d2      (hist_d2),
        .state_flat (err_state_flat)
    );

    nshp_feedback_sum #(
        .IN_W  (IN_W),
        .ERR_W (ERR_W),
        .ACC_W (ACC_W)
    ) u_sum (
        .sample (in_sample),
        .err_d1 (hist_d1),
        .err_d2 (hist_d2),
        .acc    (loop_acc)
    );

    nshp_quantizer #(
        .ACC_W (ACC_W),
        .SHIFT (SHIFT),
        .OUT_W (OUT_W),
        .ERR_W (ERR_W)
    ) u_quant (
        .acc     (loop_acc),
        .code    (code_next),
        .err_new (err_next)
    );

    // Output register: strobe follows input, data holds between samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_chan  <= '0;
            out_code  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_chan <= in_chan;
                out_code <= code_next;
            end
        end
    end

endmodule

// File: rtl/nshp_checker.sv
// Protocol and state checks for nshp_top, attached by bind.
// Assumes: state_flat holds per-channel {d2, d1} slices of the error history.
module nshp_checker #(
    parameter int CHANNELS = 2,
    parameter int ERR_W    = 14,
    parameter int CH_W     = 1,
    parameter int OUT_W    = 5
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         in_valid,
    input logic [CH_W-1:0]              in_chan,
    input logic                         out_valid,
    input logic [CH_W-1:0]              out_chan,
    input logic [OUT_W-1:0]             out_code,
    input logic [CHANNELS*2*ERR_W-1:0]  state_flat
);

    // R1: leaving reset, no output strobe and all history zero.
    a_r1_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && (state_flat == '0)));

    // R2: a sample yields a strobe next cycle.
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2: no sample, no strobe, held output data.
    a_r2_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_code) && $stable(out_chan)));

    // R2: channel index carried through.
    a_r2_chan_echo: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_chan == $past(in_chan)));

    // R6: idle cycles change no history.
    a_r6_idle_history: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(state_flat));

    // R6: a sample leaves every other channel's history untouched.
    generate
        for (genvar g = 0; g < CHANNELS; g++) begin : g_iso
            a_r6_other_chan: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && (in_chan != CH_W'(g)))
                |=> $stable(state_flat[g*2*ERR_W +: 2*ERR_W]));
        end
    endgenerate

endmodule

bind nshp_top nshp_checker #(
    .CHANNELS (CHANNELS),
    .ERR_W    (ERR_W),
    .CH_W     (CH_W),
    .OUT_W    (OUT_W)
) u_nshp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_chan    (in_chan),
    .out_valid  (out_valid),
    .out_chan   (out_chan),
    .out_code   (out_code),
    .state_flat (err_state_flat)
);

// File: tb/test_nshp_top.sv
// Scoreboard bench: send() runs an integer model and queues expected codes;
// the monitor pops and compares each code as it appears.
module test_nshp_top;

    localparam int CLK_PERIOD = 10;
    localparam int CHW        = nshp_pkg::chan_bits(2);

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_valid = 1'b0;
    logic [CHW-1:0]          in_chan = '0;
    logic signed [17:0]      in_sample = '0;
    logic                    out_valid;
    logic [CHW-1:0]          out_chan;
    logic signed [4:0]       out_code;

    int n_cmp = 0;
    int n_bad = 0;
    int me1 [2];
    int me2 [2];
    int exp_code [$];
    int exp_chan [$];
    int hist [$];
    longint msum [2];

    nshp_top i_nshp_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_chan   (in_chan),
        .in_sample (in_sample),
        .out_valid (out_valid),
        .out_chan  (out_chan),
        .out_code  (out_code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check_int(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Integer model of the loop (R3).
    function automatic int model_step(input int ch, input int x);
        int v, q, e;
        v = x + 2 * me1[ch] - me2[ch];
        q = v >>> 13;
        if (q > 15)  q = 15;
        if (q < -16) q = -16;
        e = v - (q * 8192 + 4096);
        if (e > 8191)  e = 8191;
        if (e < -8192) e = -8192;
        me2[ch] = me1[ch];
        me1[ch] = e;
        return q;
    endfunction

    // Present one sample for one cycle; called at a falling edge.
    task automatic send(input int ch, input int x);
        exp_code.push_back(model_step(ch, x));
        exp_chan.push_back(ch);
        in_valid  = 1'b1;
        in_chan   = CHW'(ch);
        in_sample = 18'(x);
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check_int("R1 out_valid in reset", int'(out_valid), 0);
        check_int("R1 out_code in reset", int'(out_code), 0);
        rst_n = 1'b1;
        for (int c = 0; c < 2; c++) begin
            me1[c] = 0;
            me2[c] = 0;
            msum[c] = 0;
        end
        exp_code.delete();
        exp_chan.delete();
        hist.delete();
        @(negedge clk);
    endtask

    // Monitor: compare every produced code against the scoreboard (R2, R3).
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_code.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R2 unexpected strobe: actual 1 expected 0");
            end else begin
                int ec, eh;
                ec = exp_code.pop_front();
                eh = exp_chan.pop_front();
                check_int("R2 out_chan", int'(out_chan), eh);
                check_int("R3 out_code", int'(out_code), ec);
                hist.push_back(int'(out_code));
                msum[int'(out_chan)] += longint'(int'(out_code)) * 8192 + 4096;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int lcg;
        int x;
        logic signed [17:0] r18;
        @(negedge clk);
        do_reset();

        // R7: idle pattern from zero history; R1: first code uses zero history.
        for (int i = 0; i < 8; i++) send(0, 0);
        idle(2);
        begin
            int pat [4] = '{0, -1, -1, 0};
            for (int i = 0; i < 8; i++)
                check_int($sformatf("R7 zero pattern #%0d", i), hist[i], pat[i % 4]);
        end
        check_int("R2 quiet after burst", int'(out_valid), 0);

        // R6: break left pattern, overload right, idle, resume left in phase.
        do_reset();
        send(0, 0);
        send(0, 0);
        for (int i = 0; i < 5; i++) send(1, 131071);
        idle(4);
        send(0, 0);
        send(0, 0);
        idle(2);
        check_int("R6 left resumes phase a", hist[7], -1);
        check_int("R6 left resumes phase b", hist[8], 0);
        check_int("R2 out_chan left after right", int'(out_chan), 0);

        // R4: positive and negative full scale held.
        do_reset();
        for (int i = 0; i < 6; i++) send(1, 131071);
        idle(2);
        for (int i = 0; i < 6; i++)
            check_int("R4 positive saturation", hist[i], 15);
        hist.delete();
        for (int i = 0; i < 6; i++) send(0, -131072);
        idle(2);
        for (int i = 0; i < 6; i++)
            check_int("R4 negative saturation", hist[i], -16);

        // R5: recovery after negative overload.
        hist.delete();
        for (int i = 0; i < 10; i++) send(0, 0);
        idle(2);
        for (int i = 4; i < 10; i++) begin
            check_int("R5 recovered code in {-1,0}",
                      ((hist[i] == 0) || (hist[i] == -1)) ? 1 : 0, 1);
        end
        // R5 positive side: recovery checked against the model.
        for (int i = 0; i < 6; i++) send(1, 131071);
        for (int i = 0; i < 10; i++) send(1, 0);
        idle(2);

        // R8: DC tracking for positive and negative constants.
        msum[0] = 0;
        for (int i = 0; i < 64; i++) send(0, 50000);
        idle(2);
        begin
            longint d;
            d = msum[0] - 64 * 50000;
            if (d < 0) d = -d;
            check_int("R8 mean tracks +50000", (d <= 32768) ? 1 : 0, 1);
        end
        msum[1] = 0;
        for (int i = 0; i < 100; i++) send(1, -70000);
        idle(2);
        begin
            longint d;
            d = msum[1] - 100 * (-70000);
            if (d < 0) d = -d;
            check_int("R8 mean tracks -70000", (d <= 32768) ? 1 : 0, 1);
        end

        // R3: pseudo-random interleaved stream, with gaps and full-range values.
        lcg = 32'h1234_5678;
        for (int i = 0; i < 400; i++) begin
            lcg = lcg * 1103515245 + 12345;
            r18 = lcg[31:14];
            x = int'(r18);
            if ((i % 50) < 5) x = (i % 2 == 0) ? 131071 : -131072;
            send(i % 3 == 0 ? 1 : 0, x);
            if (lcg[3:0] == 4'h0) idle(1);
        end
        idle(3);
        check_int("R2 scoreboard drained", exp_code.size(), 0);

        // R1: reset mid-stream restores zero history.
        for (int i = 0; i < 3; i++) send(1, 77777);
        do_reset();
        send(1, 0);
        idle(2);
        check_int("R1 first code after reset", hist[0], 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule